// File: doc/BRIEF.md
# Sign-Class Branch Condition Unit

This unit decides, in the same cycle, whether a conditional branch is taken. It receives a two's-complement data word and a three-bit condition mask from the branch instruction. It sorts the word into one of three sign classes: below zero, equal to zero, or above zero. It then reports taken when the mask enables that class.

The unit has no clock and no state. It sits between the register read data and the next-PC select of a processor datapath. Storing condition codes, fetching instructions and forming the branch target all happen elsewhere.

Top module: `nzp_branch_eval`

## Requirements
- R1: The mask bits have fixed meanings: `cond_mask[2]` enables the below-zero class, `cond_mask[1]` enables the equal-to-zero class, and `cond_mask[0]` enables the above-zero class.
- R2: For any data word, exactly one of the three sign classes is true.
- R3: The word is in the below-zero class exactly when its most significant bit (bit 15 at the default width) is 1.
- R4: The word is in the equal-to-zero class exactly when every bit is 0.
- R5: The word is in the above-zero class exactly when it is neither below zero nor equal to zero.
- R6: `br_taken` is 1 when the class of the word is enabled in the mask, and 0 otherwise (fall-through). For example, mask 3'b110 takes the branch for a below-zero word or a zero word.
- R7: Mask 3'b000 never takes the branch, whatever the word.
- R8: Mask 3'b111 always takes the branch, whatever the word.
- R9: The boundary words fall into these classes: 16'h8000 and 16'hFFFF are below zero, 16'h7FFF and 16'h0001 are above zero, and 16'h0000 is only equal to zero.
- R10: `br_taken` is purely combinational. It follows any change on the inputs without waiting for a clock edge and without any reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_word | input | 16 | Two's-complement value under test |
| cond_mask | input | 3 | Enabled classes: [2] below zero, [1] zero, [0] above zero |
| br_taken | output | 1 | 1 = branch taken, 0 = fall through |

## Verification
The assertions are evaluated whenever the inputs change. They check four things:
- exactly one class is true (one-hot);
- an all-clear mask never takes the branch;
- an all-set mask always takes it;
- with a single-class mask, the output matches the sign bit or the all-zero test of the word.

The bench's scenarios are needed to show the remaining behaviour. This covers the full mask-by-value cross product, the exact boundary words at the extremes of the signed range, and the output following new inputs within one cycle with no clock involved.

// File: rtl/nzp_pkg.sv
package nzp_pkg;

    localparam int DATA_W  = 16;
    localparam int N_CLASS = 3;

    // Mask bit positions, in the order the instruction field uses.
    localparam int MBIT_NEG  = 2;
    localparam int MBIT_ZERO = 1;
    localparam int MBIT_POS  = 0;

    // Sign class of a data word; the packed order matches the mask field.
    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } sign_class_t;

    function automatic logic class_enabled(input sign_class_t cls,
                                           input logic [N_CLASS-1:0] mask);
        logic [N_CLASS-1:0] lanes;
        lanes = {cls.neg, cls.zero, cls.pos} & mask;
        return |lanes;
    endfunction

endpackage

// File: rtl/nzp_classifier.sv
module nzp_classifier
    import nzp_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] word_in,
    output sign_class_t      cls_out
);
    localparam int MSB = WIDTH - 1;

    logic is_neg;
    logic is_zero;

    assign is_neg  = word_in[MSB];
    assign is_zero = ~(|word_in);

    always_comb begin
        cls_out.neg  = is_neg;
        cls_out.zero = is_zero;
        cls_out.pos  = ~is_neg & ~is_zero;
    end

    // R2: exactly one class is true for any known word.
    always_comb begin
        if (!$isunknown(word_in)) begin
            a_r2_one_class: assert ($onehot({cls_out.neg, cls_out.zero, cls_out.pos}))
                else $error("class vector not one-hot");
        end
    end

endmodule

// File: rtl/nzp_mask_match.sv
module nzp_mask_match
    import nzp_pkg::*;
(
    input  sign_class_t        cls_in,
    input  logic [N_CLASS-1:0] mask_in,
    output logic               hit
);
    logic [N_CLASS-1:0] cls_vec;
    logic [N_CLASS-1:0] lane_hit;

    assign cls_vec = {cls_in.neg, cls_in.zero, cls_in.pos};

    // One enable lane per sign class.
    for (genvar g = 0; g < N_CLASS; g++) begin : g_lane
        assign lane_hit[g] = cls_vec[g] & mask_in[g];
    end

    assign hit = |lane_hit;

    // R6: at most one lane can fire, since the classes are exclusive.
    always_comb begin
        if (!$isunknown({cls_vec, mask_in})) begin
            a_r6_single_lane: assert ($countones(lane_hit) <= 1)
                else $error("more than one lane hit");
        end
    end

endmodule

// File: rtl/nzp_branch_eval.sv
module nzp_branch_eval
    import nzp_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0]   data_word,
    input  logic [N_CLASS-1:0] cond_mask,
    output logic               br_taken
);
    sign_class_t cls;

    nzp_classifier #(.WIDTH(WIDTH)) u_class (
        .word_in (data_word),
        .cls_out (cls)
    );

    nzp_mask_match u_match (
        .cls_in  (cls),
        .mask_in (cond_mask),
        .hit     (br_taken)
    );

    always_comb begin
        if (!$isunknown({data_word, cond_mask})) begin
            // R7: an all-clear mask never takes the branch.
            a_r7_mask_none: assert (!(cond_mask == 3'b000 && br_taken))
                else $error("taken with empty mask");
            // R8: an all-set mask always takes the branch.
            a_r8_mask_all: assert (!(cond_mask == 3'b111 && !br_taken))
                else $error("not taken with full mask");
            // R3: with only the below-zero bit set, the outcome is the sign bit.
            if (cond_mask == (3'b1 << MBIT_NEG)) begin
                a_r3_neg_msb: assert (br_taken == data_word[WIDTH-1])
                    else $error("negative test mismatch");
            end
            // R4: with only the zero bit set, the outcome is the all-zero test.
            if (cond_mask == (3'b1 << MBIT_ZERO)) begin
                a_r4_zero_word: assert (br_taken == (data_word == '0))
                    else $error("zero test mismatch");
            end
            // R5: with only the above-zero bit set.
            if (cond_mask == (3'b1 << MBIT_POS)) begin
                a_r5_pos_word: assert (br_taken == (!data_word[WIDTH-1] && data_word != '0))
                    else $error("positive test mismatch");
            end
        end
    end

endmodule

// File: tb/nzp_branch_eval_test.sv
module nzp_branch_eval_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] data_word = '0;
    logic [2:0]  cond_mask = '0;
    logic        br_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    nzp_branch_eval uut (
        .data_word (data_word),
        .cond_mask (cond_mask),
        .br_taken  (br_taken)
    );

    // Table of value, mask, expected outcome.
    localparam int NV = 14;
    localparam logic [15:0] TV_VAL [NV] = '{
        16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001, 16'h0000, 16'h1234,
        16'hC000, 16'h0000, 16'h0000, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h4000
    };
    localparam logic [2:0] TV_MSK [NV] = '{
        3'b100, 3'b001, 3'b010, 3'b100, 3'b001, 3'b110, 3'b110,
        3'b110, 3'b101, 3'b011, 3'b011, 3'b110, 3'b001, 3'b010
    };
    localparam logic TV_EXP [NV] = '{
        1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
        1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0
    };

    // Independent model: signed compare against zero.
    function automatic logic model(input logic [15:0] v, input logic [2:0] m);
        logic n, z, p;
        n = ($signed(v) < 0);
        z = (v == 16'd0);
        p = ($signed(v) > 0);
        return (m[2] && n) || (m[1] && z) || (m[0] && p);
    endfunction

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (br_taken !== exp) begin
            n_fail++;
            $display("FAIL %s: value=%h mask=%b actual=%b expected=%b",
                     req, data_word, cond_mask, br_taken, exp);
        end
    endtask

    task automatic apply(input logic [15:0] v, input logic [2:0] m);
        @(negedge clk);
        data_word = v;
        cond_mask = m;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Initial state: zero word with empty mask is not taken (R7).
        apply(16'h0000, 3'b000);
        check("R7 initial", 1'b0);

        // Table walk (R1, R6, R9).
        for (int i = 0; i < NV; i++) begin
            apply(TV_VAL[i], TV_MSK[i]);
            check("R6/R9 table", TV_EXP[i]);
        end

        // Cross product of words and all masks (R1, R2, R6).
        begin
            logic [15:0] words [8];
            words = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                      16'hFFFF, 16'h00F0, 16'hA5A5, 16'h5A5A};
            for (int w = 0; w < 8; w++) begin
                for (int m = 0; m < 8; m++) begin
                    apply(words[w], 3'(m));
                    check("R1/R2 cross", model(words[w], 3'(m)));
                end
            end
        end

        // Each single bit set, alone (R3, R4).
        for (int b = 0; b < 16; b++) begin
            apply(16'h1 << b, 3'b100);
            check("R3 single bit", (b == 15));
            apply(16'h1 << b, 3'b010);
            check("R4 single bit", 1'b0);
            apply(16'h1 << b, 3'b001);
            check("R5 single bit", (b != 15));
        end

        // Mask 000 and 111 over boundary words (R7, R8).
        apply(16'h8000, 3'b000); check("R7 none", 1'b0);
        apply(16'h7FFF, 3'b000); check("R7 none", 1'b0);
        apply(16'h8000, 3'b111); check("R8 all", 1'b1);
        apply(16'h0000, 3'b111); check("R8 all", 1'b1);
        apply(16'h7FFF, 3'b111); check("R8 all", 1'b1);

        // Combinational response between edges, no clock needed (R10).
        @(posedge clk);
        #1;
        data_word = 16'h0000; cond_mask = 3'b010; #0.5;
        check("R10 comb", 1'b1);
        data_word = 16'hFFFF; #0.5;
        check("R10 comb", 1'b0);
        cond_mask = 3'b100; #0.5;
        check("R10 comb", 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule